// File: doc/BRIEF.md
# Coordinated Soft-Step Gain Controller

This block steers the gain codes of several audio gain stages (volume, speaker, loudness, treble, middle and bass stages) so that a change of setting is spread over a fixed transition instead of landing as a single jump. Settings arrive as one byte per write, addressed to one stage. A byte either applies its gain at once (soft-step off) or hands it to the ramp engine (soft-step on). A soft-step write may be marked "wait", which parks its target, or "act", which launches a ramp session. Every parked stage then moves together with the stage that launched the session.

One session runs at a time across all stages. It advances on a sample-rate tick, and its length is set by two mode inputs that select between an S-shaped curve and a linear curve, each with a short or a long duration. An act write that arrives during a session is held back and launches on the first tick after the session ends. The output is one signed gain code per stage, together with an active-low busy flag.

Top module: `softstep_gain_ctrl`

## Requirements
- R1: After reset every stage gain code is 0 and `busy_n` is 1.
- R2: A write byte has the wait flag in bit 7 (1 = wait, 0 = act), the soft-step enable in bit 6 (1 = on) and a signed two's-complement gain code in bits 5:0. A write whose stage index is not below the stage count is ignored entirely.
- R3: A write with soft-step off shows its gain on that stage's output after the next clock edge. It starts no session, and it cancels any pending or active ramp of that stage.
- R4: A soft-step write with the wait flag leaves the outputs and `busy_n` unchanged, however many ticks follow.
- R5: After a soft-step act write, the next tick at which no session is running launches a session. That tick does not move any gain, and `busy_n` is 0 from that edge onward. Every stage holding a parked target joins the session, and stages without one hold their gain.
- R6: The session length N in ticks is selected at launch: S curve short 15, S curve long 30, linear short 10, linear long 20 (`curve_lin`, `time_long`). The k-th tick after launch (k = 1..N) updates the gains. At k = N each ramping stage equals its target and `busy_n` returns to 1.
- R7: With the linear curve, the gain after the k-th step is s + ((t - s) * (k*256/N)) / 256, where s is the start gain, t is the target, and both divisions truncate toward zero.
- R8: With the S curve, the weight is w(i) = (24*i*i - i*i*i)/8 with i = k*16/N, and the gain is s + ((t - s) * w) / 256.
- R9: A stage that receives target A with wait and then target B with act ramps from its current gain straight to B.
- R10: An act write during a session does not disturb the running ramps, including a ramp on the written stage. It launches on the first tick after `busy_n` returns to 1.
- R11: While a stage ramps, its gain stays between its start gain and its target.
- R12: Gains change only on tick edges or through soft-step-off writes. A cycle without a tick leaves a session's progress frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-rate step strobe |
| wr_en | input | 1 | Write strobe for one byte |
| wr_stage | input | $clog2(NS) | Stage addressed by the write |
| wr_data | input | 8 | Wait flag, soft-step enable, gain code |
| curve_lin | input | 1 | 1 selects the linear curve, 0 the S curve |
| time_long | input | 1 | 1 selects the long transition |
| gain_o | output | NS*GW | Per-stage signed gain codes, stage i at bits i*GW upward |
| busy_n | output | 1 | 0 while a session runs |

## Verification
A soft-step-off write is due on the output one clock after its strobe. A launching tick changes only `busy_n`, in the cycle after it. The k-th following tick gives the k-th interpolated code one clock later. All stimulus is applied on falling edges and every result is read on the falling edge after the rising edge that produces it, so each check lands exactly one register stage after its cause. Inserted idle cycles without a tick confirm that nothing moves between ticks. The sweep covers all four curve and length modes across a grid of start and target codes.

// File: rtl/softstep_gain_ctrl.sv
module softstep_gain_ctrl #(
  parameter int NS      = 6,
  parameter int GW      = 6,
  parameter int S_SHORT = 15,
  parameter int S_LONG  = 30,
  parameter int L_SHORT = 10,
  parameter int L_LONG  = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    wr_en,
  input  logic [$clog2(NS)-1:0]   wr_stage,
  input  logic [7:0]              wr_data,
  input  logic                    curve_lin,
  input  logic                    time_long,
  output logic [NS*GW-1:0]        gain_o,
  output logic                    busy_n
);
  localparam int M1   = (S_SHORT > S_LONG) ? S_SHORT : S_LONG;
  localparam int M2   = (L_SHORT > L_LONG) ? L_SHORT : L_LONG;
  localparam int LMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(LMAX + 1);

  function automatic int scw(input int i);
    return (24 * i * i - i * i * i) / 8;
  endfunction

  function automatic logic signed [GW-1:0] mix(input logic signed [GW-1:0] a,
                                               input logic signed [GW-1:0] b,
                                               input int w);
    return GW'(int'(a) + ((int'(b) - int'(a)) * w) / 256);
  endfunction

  logic signed [GW-1:0] cur [NS];
  logic signed [GW-1:0] st  [NS];
  logic signed [GW-1:0] tg  [NS];
  logic signed [GW-1:0] pt  [NS];
  logic [NS-1:0] pend, ramp;
  logic          go_q, sess, lin_q;
  logic [CW-1:0] pos, len_q;
  int            wgt;

  wire wv     = wr_en && (int'(wr_stage) < NS);
  wire wwait  = wr_data[7];
  wire wss    = wr_data[6];
  wire signed [GW-1:0] wcode = GW'($signed(wr_data[5:0]));
  wire launch = tick && !sess && go_q;
  wire step   = tick && sess;
  wire [CW-1:0] pnx  = pos + 1'b1;
  wire          last = step && (pnx == len_q);
  wire [CW-1:0] mlen = curve_lin ? (time_long ? CW'(L_LONG) : CW'(L_SHORT))
                                 : (time_long ? CW'(S_LONG) : CW'(S_SHORT));

  always_comb
    wgt = lin_q ? (int'(pnx) * 256) / int'(len_q)
                : scw((int'(pnx) * 16) / int'(len_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        cur[i] <= '0; st[i] <= '0; tg[i] <= '0; pt[i] <= '0;
      end
      pend  <= '0;
      ramp  <= '0;
      go_q  <= 1'b0;
      sess  <= 1'b0;
      lin_q <= 1'b0;
      pos   <= '0;
      len_q <= CW'(S_SHORT);
    end else begin
      if (launch) begin
        sess  <= 1'b1;
        pos   <= '0;
        len_q <= mlen;
        lin_q <= curve_lin;
        go_q  <= 1'b0;
        ramp  <= pend;
        pend  <= '0;
        for (int i = 0; i < NS; i++)
          if (pend[i]) begin
            st[i] <= cur[i];
            tg[i] <= pt[i];
          end
      end
      if (step) begin
        pos <= pnx;
        for (int i = 0; i < NS; i++)
          if (ramp[i]) cur[i] <= last ? tg[i] : mix(st[i], tg[i], wgt);
        if (last) begin
          sess <= 1'b0;
          ramp <= '0;
        end
      end
      if (wv) begin
        if (!wss) begin
          cur[wr_stage]  <= wcode;
          ramp[wr_stage] <= 1'b0;
          pend[wr_stage] <= 1'b0;
        end else begin
          pt[wr_stage]   <= wcode;
          pend[wr_stage] <= 1'b1;
          if (!wwait) go_q <= 1'b1;
        end
      end
    end
  end

  assign busy_n = ~sess;

  for (genvar g = 0; g < NS; g++) begin : g_out
    assign gain_o[g*GW +: GW] = cur[g];

    // R11
    ramp_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sess && ramp[g]) |->
        ((cur[g] >= st[g] && cur[g] <= tg[g]) || (cur[g] <= st[g] && cur[g] >= tg[g])));

    // R6
    ramp_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy_n) && $past(ramp[g]) &&
       !$past(wr_en && !wr_data[6] && int'(wr_stage) == g)) |-> (cur[g] == tg[g]));
  end

  // R6
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sess |-> (pos < len_q));

  // R12
  frozen_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(wr_en && !wr_data[6])) |=> $stable(gain_o));

  // R5
  launch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> ($past(tick) && $past(go_q)));

  // R10
  one_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sess && !last) |=> sess);
endmodule

// File: tb/softstep_gain_ctrl_test.sv
module softstep_gain_ctrl_test;
  localparam int NS = 6;
  localparam int GW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_stage = '0;
  logic [7:0] wr_data = '0;
  logic curve_lin = 1'b0;
  logic time_long = 1'b0;
  logic [NS*GW-1:0] gain_o;
  logic busy_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  softstep_gain_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_stage(wr_stage),
    .wr_data(wr_data), .curve_lin(curve_lin), .time_long(time_long),
    .gain_o(gain_o), .busy_n(busy_n)
  );

  function automatic int g(input int s);
    logic signed [GW-1:0] v;
    v = gain_o[s*GW +: GW];
    return int'(v);
  endfunction

  function automatic int mlen(input bit lin, input bit lng);
    return lin ? (lng ? 20 : 10) : (lng ? 30 : 15);
  endfunction

  function automatic int expv(input int s, input int t, input int k, input int n, input bit lin);
    int w, i;
    if (lin) w = (k * 256) / n;
    else begin
      i = (k * 16) / n;
      w = (24 * i * i - i * i * i) / 8;
    end
    return s + ((t - s) * w) / 256;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int s, input bit wt, input bit ss, input int code);
    @(negedge clk);
    wr_en = 1'b1; wr_stage = 3'(s); wr_data = {wt, ss, 6'(code)};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base[NS];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < NS; s++) chk("R1 gain", g(s), 0);
    chk("R1 busy_n", int'(busy_n), 1);

    // R3 immediate writes over all stages and all codes
    for (int s = 0; s < NS; s++)
      for (int c = -32; c < 32; c += 3) begin
        wr(s, 1'b0, 1'b0, c);
        chk("R3 immediate", g(s), c);
        chk("R3 no session", int'(busy_n), 1);
      end
    for (int s = 0; s < NS; s++) begin
      wr(s, 1'b0, 1'b0, s * 3 - 7);
      base[s] = s * 3 - 7;
    end

    // R2 out-of-range stage ignored
    wr(6, 1'b0, 1'b0, 9);
    wr(7, 1'b0, 1'b1, 9);
    repeat (3) tk();
    for (int s = 0; s < NS; s++) chk("R2 ignored stage", g(s), base[s]);
    chk("R2 ignored act", int'(busy_n), 1);

    // R4 wait write only parks
    wr(0, 1'b1, 1'b1, 10);
    repeat (5) tk();
    chk("R4 gain held", g(0), base[0]);
    chk("R4 busy_n", int'(busy_n), 1);
    wr(0, 1'b0, 1'b0, base[0]);

    // R6 R7 R8 sweep over modes and start/target pairs on stage 2
    for (int m = 0; m < 4; m++) begin
      curve_lin = m[1]; time_long = m[0];
      for (int sv = -23; sv <= 23; sv += 15)
        for (int tv = -21; tv <= 23; tv += 11) begin
          int n;
          n = mlen(m[1], m[0]);
          wr(2, 1'b0, 1'b0, sv);
          wr(2, 1'b0, 1'b1, tv);
          chk("R5 pre-launch busy_n", int'(busy_n), 1);
          tk();
          chk("R5 launch busy_n", int'(busy_n), 0);
          chk("R5 launch holds gain", g(2), sv);
          for (int k = 1; k <= n; k++) begin
            tk();
            chk(m[1] ? "R7 linear step" : "R8 s-curve step", g(2), expv(sv, tv, k, n, m[1]));
            chk("R6 busy_n", int'(busy_n), (k == n) ? 1 : 0);
            if (k == n / 2) begin
              repeat (2) @(negedge clk);
              chk("R12 no tick no move", g(2), expv(sv, tv, k, n, m[1]));
            end
          end
          chk("R6 target reached", g(2), tv);
        end
    end

    // R5 parallel launch
    curve_lin = 1'b0; time_long = 1'b0;
    for (int s = 0; s < NS; s++) begin
      wr(s, 1'b0, 1'b0, 2 * s - 5);
      base[s] = 2 * s - 5;
    end
    wr(0, 1'b1, 1'b1, 20);
    wr(1, 1'b1, 1'b1, -18);
    wr(3, 1'b1, 1'b1, 4);
    wr(4, 1'b1, 1'b1, -23);
    wr(5, 1'b0, 1'b1, 23);
    tk();
    chk("R5 parallel busy_n", int'(busy_n), 0);
    for (int k = 1; k <= 15; k++) begin
      tk();
      chk("R5 stage0", g(0), expv(base[0], 20, k, 15, 1'b0));
      chk("R5 stage1", g(1), expv(base[1], -18, k, 15, 1'b0));
      chk("R5 idle stage2", g(2), base[2]);
      chk("R5 stage3", g(3), expv(base[3], 4, k, 15, 1'b0));
      chk("R5 stage4", g(4), expv(base[4], -23, k, 15, 1'b0));
      chk("R5 stage5", g(5), expv(base[5], 23, k, 15, 1'b0));
    end
    chk("R5 end busy_n", int'(busy_n), 1);

    // R9 wait A then act B
    curve_lin = 1'b0; time_long = 1'b1;
    wr(1, 1'b0, 1'b0, 0);
    wr(1, 1'b1, 1'b1, 20);
    wr(1, 1'b0, 1'b1, -15);
    tk();
    for (int k = 1; k <= 30; k++) begin
      tk();
      chk("R9 direct to B", g(1), expv(0, -15, k, 30, 1'b0));
    end

    // R10 queued act during a session
    curve_lin = 1'b1; time_long = 1'b0;
    wr(0, 1'b0, 1'b0, 0);
    wr(3, 1'b0, 1'b0, 5);
    wr(0, 1'b0, 1'b1, 20);
    tk();
    for (int k = 1; k <= 3; k++) begin
      tk();
      chk("R10 first ramp", g(0), expv(0, 20, k, 10, 1'b1));
    end
    wr(3, 1'b1, 1'b1, -5);
    wr(0, 1'b0, 1'b1, -10);
    for (int k = 4; k <= 10; k++) begin
      tk();
      chk("R10 undisturbed ramp", g(0), expv(0, 20, k, 10, 1'b1));
      chk("R10 queued stage holds", g(3), 5);
      chk("R10 busy_n", int'(busy_n), (k == 10) ? 1 : 0);
    end
    tk();
    chk("R10 queued launch busy_n", int'(busy_n), 0);
    chk("R10 launch holds gain", g(0), 20);
    for (int k = 1; k <= 10; k++) begin
      tk();
      chk("R10 second ramp stage0", g(0), expv(20, -10, k, 10, 1'b1));
      chk("R10 second ramp stage3", g(3), expv(5, -5, k, 10, 1'b1));
    end
    chk("R10 final busy_n", int'(busy_n), 1);

    // R3 soft-step off cancels a running ramp
    wr(4, 1'b0, 1'b1, 15);
    tk();
    tk();
    wr(4, 1'b0, 1'b0, -3);
    chk("R3 cancel", g(4), -3);
    repeat (12) tk();
    chk("R3 cancel held", g(4), -3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule